// File: doc/BRIEF.md
# UTOPIA Receive-Side PHY Cell Source

This block is the physical-layer end of a UTOPIA receive link. The ATM layer device supplies the clock. It polls the block through a 5-bit address and an active-low enable, and it pulls complete 53-byte cells out of the block. Cells reach the block through a plain word write port and wait in an internal word store. The receive bus carries either 16-bit words (27 per cell) or single bytes (53 per cell). The block drives a start-of-cell flag, a parity bit of selectable sense and a cell-available flag.

Several PHY devices can share the bus. For this reason the block computes no pad states itself: it gives one drive-enable for the data group (data, start-of-cell, parity) and one for cell-available, and the pad ring uses them to steer tri-state buffers.

A static strap selects single-PHY or multi-PHY operation. In single-PHY mode the address is ignored and the port counts as always selected. A new cell then begins only on a falling edge of enable. In multi-PHY mode the port is selected by the address seen in the most recent cycle with enable high.

Top module: `utopia_rx_phy`

## Requirements
- R1: While reset is held and at its release, rxDataOe, rxSoc, rxClav and rxClavOe are 0 and wrReady is 1.
- R2: rxDataOe is 1 in a cycle exactly when, in the cycle before, rxEnN was 0 and the port was selected. Data, start-of-cell and parity are valid only while rxDataOe is 1.
- R3: In multi-PHY mode (multiPhy=1) the port is selected when rxAddr equalled portAddr in the most recent cycle with rxEnN=1. Cycles with rxEnN=0 leave the selection unchanged.
- R4: Words leave in the order they were written. rxSoc is 1 with the first word of each cell. A cell is 27 words when busWide=1, or 53 bytes on rxData[7:0] with rxData[15:8]=0 when busWide=0.
- R5: rxPar makes the count of ones in {rxData,rxPar} odd when oddPar=1 and even when oddPar=0.
- R6: When rxEnN goes high partway through a cell, no word is consumed. The cell continues with its next word once rxEnN is low again with the port selected.
- R7: In single-PHY mode (multiPhy=0) a cell starts only in a cycle where rxEnN is 0 and was 1 in the cycle before. Holding rxEnN low past a cell's last word starts no further cell.
- R8: rxClav is 1 while at least one fully written cell has not yet started. rxClavOe is 1 in the cycle after rxAddr equalled portAddr in multi-PHY mode, and always 1 after the first clock in single-PHY mode.
- R9: A write is accepted when wrEn=1 and wrReady=1. wrReady is 0 when the store holds CELLS*53 words. In byte mode only wrData[7:0] is kept.
- R10: When a write that completes a cell and the start of another cell fall in the same cycle, the count of waiting cells stays exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive interface clock supplied by the ATM layer |
| rstN | input | 1 | Active-low synchronous reset |
| busWide | input | 1 | 1 selects 16-bit words, 0 selects bytes (static) |
| multiPhy | input | 1 | 1 selects shared-bus addressed operation (static) |
| oddPar | input | 1 | 1 selects odd parity, 0 selects even (static) |
| portAddr | input | 5 | Address this port answers to |
| rxEnN | input | 1 | Active-low transfer enable from the ATM layer |
| rxAddr | input | 5 | Poll and select address from the ATM layer |
| rxData | output | 16 | Cell data word or byte |
| rxSoc | output | 1 | High with the first word of a cell |
| rxPar | output | 1 | Parity over rxData |
| rxDataOe | output | 1 | Drive enable for rxData, rxSoc and rxPar |
| rxClav | output | 1 | Cell-available flag |
| rxClavOe | output | 1 | Drive enable for rxClav |
| wrEn | input | 1 | Write strobe of the cell store |
| wrData | input | 16 | Word to store |
| wrReady | output | 1 | Store has room for a word |

## Verification
Two things can happen in the same clock edge. A write can deliver the last word of a cell while a read takes the first word of another waiting cell, so the waiting-cell count is raised and lowered at once. The bench forces this directly. It preloads one full cell and all but one word of a second, then drops enable in the same cycle as the final write. Random traffic with writes and enables on together also reaches this case often. The bench judges the result with its own queue model of stored words and waiting cells: it checks that the cell-available flag and every following start-of-cell and word match the model.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;

  localparam int CELL_BYTES = 53;
  localparam int WIDE_WORDS = (CELL_BYTES + 1) / 2;

  // strobes from the control into the datapath
  typedef struct packed {
    logic loadWord;   // present the next stored word
    logic markStart;  // that word opens a cell
    logic driveBus;   // drive the data group next cycle
  } rdStrobe_t;

endpackage

// File: rtl/utopia_rx_ctrl.sv
module utopia_rx_ctrl
  import utopia_rx_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWide,
  input  logic              multiPhy,
  input  logic [ADDR_W-1:0] portAddr,
  input  logic              rxEnN,
  input  logic [ADDR_W-1:0] rxAddr,
  input  logic              cellReady,
  output rdStrobe_t         strobe,
  output logic              clavOe
);

  localparam int IDX_W = $clog2(CELL_BYTES);
  localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(WIDE_WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(CELL_BYTES - 1);

  logic             selQ;
  logic             prevEnNQ;
  logic             inCellQ;
  logic [IDX_W-1:0] idxQ;
  logic             clavOeQ;

  logic             addrHit;
  logic             selEff;
  logic             startOk;
  logic             wordGo;
  logic             cellStart;
  logic [IDX_W-1:0] lastIdx;

  assign addrHit  = (rxAddr == portAddr);
  assign selEff   = multiPhy ? selQ : 1'b1;
  assign lastIdx  = busWide ? LAST_WIDE : LAST_NARROW;
  // R7: single-PHY needs a high-to-low enable edge to open a cell
  assign startOk  = cellReady && (multiPhy || prevEnNQ);
  assign wordGo   = !rxEnN && selEff && (inCellQ || startOk);
  assign cellStart = wordGo && !inCellQ;

  always_comb begin
    strobe.loadWord  = wordGo;
    strobe.markStart = cellStart;
    strobe.driveBus  = !rxEnN && selEff;
  end

  assign clavOe = clavOeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ     <= 1'b0;
      prevEnNQ <= 1'b1;
      inCellQ  <= 1'b0;
      idxQ     <= '0;
      clavOeQ  <= 1'b0;
    end else begin
      prevEnNQ <= rxEnN;
      clavOeQ  <= multiPhy ? addrHit : 1'b1;
      // R3: selection follows the address while enable is idle
      if (rxEnN) selQ <= addrHit;
      if (wordGo) begin
        if (idxQ == lastIdx) begin
          inCellQ <= 1'b0;
          idxQ    <= '0;
        end else begin
          inCellQ <= 1'b1;
          idxQ    <= idxQ + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/utopia_rx_dpath.sv
module utopia_rx_dpath
  import utopia_rx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CELLS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWide,
  input  logic              oddPar,
  input  rdStrobe_t         strobe,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrReady,
  output logic              cellReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxSoc,
  output logic              rxPar,
  output logic              rxDataOe
);

  localparam int DEPTH  = CELLS * CELL_BYTES;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int USED_W = $clog2(DEPTH + 1);
  localparam int IDX_W  = $clog2(CELL_BYTES);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(WIDE_WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(CELL_BYTES - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtrQ, rdPtrQ;
  logic [USED_W-1:0] usedQ;
  logic [USED_W-1:0] readyQ;
  logic [IDX_W-1:0]  wrIdxQ;
  logic [DATA_W-1:0] dataQ;
  logic              socQ;
  logic              oeQ;

  logic              wrOk;
  logic              cellDone;
  logic [IDX_W-1:0]  lastWr;
  logic [DATA_W-1:0] wrMasked;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wrReady  = (usedQ < USED_W'(DEPTH));
  assign wrOk     = wrEn && wrReady;
  assign lastWr   = busWide ? LAST_WIDE : LAST_NARROW;
  assign cellDone = wrOk && (wrIdxQ == lastWr);
  assign wrMasked = busWide ? wrData : {{HALF_W{1'b0}}, wrData[HALF_W-1:0]};
  assign cellReady = (readyQ != '0);

  always_ff @(posedge clk) begin
    if (wrOk) mem[wrPtrQ] <= wrMasked;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtrQ <= '0;
      rdPtrQ <= '0;
      usedQ  <= '0;
      readyQ <= '0;
      wrIdxQ <= '0;
      dataQ  <= '0;
      socQ   <= 1'b0;
      oeQ    <= 1'b0;
    end else begin
      oeQ  <= strobe.driveBus;
      socQ <= strobe.markStart;
      if (wrOk) begin
        wrPtrQ <= bump(wrPtrQ);
        wrIdxQ <= cellDone ? '0 : wrIdxQ + 1'b1;
      end
      if (strobe.loadWord) begin
        dataQ  <= mem[rdPtrQ];
        rdPtrQ <= bump(rdPtrQ);
      end
      usedQ  <= usedQ + USED_W'(wrOk) - USED_W'(strobe.loadWord);
      // R10: completion and start may coincide
      readyQ <= readyQ + USED_W'(cellDone) - USED_W'(strobe.markStart);
    end
  end

  // R5
  generate
    if (DATA_W > 1) begin : g_par
      assign rxPar = oddPar ? ~^dataQ : ^dataQ;
    end else begin : g_par1
      assign rxPar = oddPar ? ~dataQ[0] : dataQ[0];
    end
  endgenerate

  assign rxData   = dataQ;
  assign rxSoc    = socQ;
  assign rxDataOe = oeQ;

endmodule

// File: rtl/utopia_rx_phy.sv
module utopia_rx_phy
  import utopia_rx_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int CELLS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWide,
  input  logic              multiPhy,
  input  logic              oddPar,
  input  logic [ADDR_W-1:0] portAddr,
  input  logic              rxEnN,
  input  logic [ADDR_W-1:0] rxAddr,
  output logic [DATA_W-1:0] rxData,
  output logic              rxSoc,
  output logic              rxPar,
  output logic              rxDataOe,
  output logic              rxClav,
  output logic              rxClavOe,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrReady
);

  rdStrobe_t strobe;
  logic      cellReady;

  utopia_rx_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busWide  (busWide),
    .multiPhy (multiPhy),
    .portAddr (portAddr),
    .rxEnN    (rxEnN),
    .rxAddr   (rxAddr),
    .cellReady(cellReady),
    .strobe   (strobe),
    .clavOe   (rxClavOe)
  );

  utopia_rx_dpath #(.DATA_W(DATA_W), .CELLS(CELLS)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .busWide  (busWide),
    .oddPar   (oddPar),
    .strobe   (strobe),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .wrReady  (wrReady),
    .cellReady(cellReady),
    .rxData   (rxData),
    .rxSoc    (rxSoc),
    .rxPar    (rxPar),
    .rxDataOe (rxDataOe)
  );

  // R8: the flag value is the waiting-cell state
  assign rxClav = cellReady;

endmodule

// File: rtl/utopia_rx_chk.sv
module utopia_rx_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              multiPhy,
  input logic              oddPar,
  input logic              rxEnN,
  input logic              rxDataOe,
  input logic              rxSoc,
  input logic [DATA_W-1:0] rxData,
  input logic              rxPar,
  input logic              rxClav
);

  // R2
  oe_after_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDataOe |-> !$past(rxEnN));

  // R2
  soc_only_driven_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxSoc |-> rxDataOe);

  // R5
  parity_sense_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDataOe |-> ((^{rxData, rxPar}) == oddPar));

  // R8
  start_needs_clav_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxSoc |-> $past(rxClav));

  // R7
  single_edge_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!multiPhy && rxSoc) |-> ($past(rxEnN, 2) && !$past(rxEnN)));

endmodule

bind utopia_rx_phy utopia_rx_chk #(.DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .multiPhy(multiPhy),
  .oddPar  (oddPar),
  .rxEnN   (rxEnN),
  .rxDataOe(rxDataOe),
  .rxSoc   (rxSoc),
  .rxData  (rxData),
  .rxPar   (rxPar),
  .rxClav  (rxClav)
);

// File: tb/utopia_rx_phy_tb.sv
`timescale 1ns/1ps
module utopia_rx_phy_tb_top;

  localparam int DEPTH = 4 * 53;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWide = 1'b1;
  logic        multiPhy = 1'b1;
  logic        oddPar = 1'b1;
  logic [4:0]  portAddr = 5'h0B;
  logic        rxEnN = 1'b1;
  logic [4:0]  rxAddr = 5'h00;
  logic [15:0] rxData;
  logic        rxSoc, rxPar, rxDataOe, rxClav, rxClavOe;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        wrReady;

  int vectors = 0;
  int errors  = 0;
  string curTag = "R4";
  bit done = 1'b0;

  // reference model state
  logic [15:0] refQ[$];
  bit mSel, mPrevEn, mInCell, mOe, mSoc, mClavOe;
  int mIdx, mWrIdx, mUsed, mComplete;
  logic [15:0] mData;

  always #4 clk = ~clk;

  utopia_rx_phy dut_i (
    .clk(clk), .rstN(rstN), .busWide(busWide), .multiPhy(multiPhy),
    .oddPar(oddPar), .portAddr(portAddr), .rxEnN(rxEnN), .rxAddr(rxAddr),
    .rxData(rxData), .rxSoc(rxSoc), .rxPar(rxPar), .rxDataOe(rxDataOe),
    .rxClav(rxClav), .rxClavOe(rxClavOe), .wrEn(wrEn), .wrData(wrData),
    .wrReady(wrReady)
  );

  function automatic logic expPar(input logic [15:0] d, input logic odd);
    int ones = $countones(d);
    return odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
  endfunction

  task automatic check(input string req, input string what, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s (%s) %s: got %0h expected %0h", req, curTag, what, got, exp);
    end
  endtask

  task automatic compareOutputs();
    check("R9", "wrReady", int'(wrReady), int'(mUsed < DEPTH));
    check("R2", "rxDataOe", int'(rxDataOe), int'(mOe));
    check("R8", "rxClav", int'(rxClav), int'(mComplete != 0));
    check("R8", "rxClavOe", int'(rxClavOe), int'(mClavOe));
    if (mOe) begin
      check("R4", "rxSoc", int'(rxSoc), int'(mSoc));
      check("R4", "rxData", int'(rxData), int'(mData));
      check("R5", "rxPar", int'(rxPar), int'(expPar(mData, oddPar)));
    end
  endtask

  task automatic modelAdvance();
    int  len     = busWide ? 27 : 53;
    bit  selEff  = multiPhy ? mSel : 1'b1;
    bit  wrOk    = wrEn && (mUsed < DEPTH);
    bit  startOk = (mComplete != 0) && (multiPhy || mPrevEn);
    bit  go      = !rxEnN && selEff && (mInCell || startOk);
    bit  start   = go && !mInCell;
    bit  fin     = wrOk && (mWrIdx == len - 1);
    mOe  = !rxEnN && selEff;
    mSoc = start;
    if (go) begin
      mData = refQ.pop_front();
      if (mIdx == len - 1) begin mInCell = 1'b0; mIdx = 0; end
      else begin mInCell = 1'b1; mIdx++; end
    end
    if (wrOk) begin
      refQ.push_back(busWide ? wrData : {8'h00, wrData[7:0]});
      mWrIdx = fin ? 0 : mWrIdx + 1;
    end
    mUsed     = mUsed + int'(wrOk) - int'(go);
    mComplete = mComplete + int'(fin) - int'(start);
    if (rxEnN) mSel = (rxAddr == portAddr);
    mPrevEn = rxEnN;
    mClavOe = multiPhy ? (rxAddr == portAddr) : 1'b1;
  endtask

  task automatic step(input logic en, input logic [4:0] a, input logic we, input logic [15:0] wd);
    @(negedge clk);
    compareOutputs();
    rxEnN = en; rxAddr = a; wrEn = we; wrData = wd;
    modelAdvance();
  endtask

  task automatic resetPhase(input logic wide, input logic multi, input logic odd);
    @(negedge clk);
    rstN = 1'b0; busWide = wide; multiPhy = multi; oddPar = odd;
    rxEnN = 1'b1; rxAddr = ~portAddr; wrEn = 1'b0; wrData = '0;
    repeat (3) @(negedge clk);
    refQ.delete();
    mSel = 0; mPrevEn = 1; mInCell = 0; mOe = 0; mSoc = 0; mClavOe = 0;
    mIdx = 0; mWrIdx = 0; mUsed = 0; mComplete = 0; mData = '0;
    // R1: reset values
    check("R1", "rxDataOe", int'(rxDataOe), 0);
    check("R1", "rxSoc", int'(rxSoc), 0);
    check("R1", "rxClav", int'(rxClav), 0);
    check("R1", "rxClavOe", int'(rxClavOe), 0);
    check("R1", "wrReady", int'(wrReady), 1);
    rstN = 1'b1;
    modelAdvance();
  endtask

  task automatic randomRun(input int n);
    for (int i = 0; i < n; i++) begin
      logic en = (($urandom % 10) < 3);
      logic [4:0] a = (($urandom % 4) != 0) ? portAddr : 5'($urandom);
      logic we = (($urandom % 10) < 6);
      step(en, a, we, 16'($urandom));
    end
  endtask

  initial begin
    int unsigned seedInit;
    seedInit = $urandom(32'd2024);

    // wide, multi-PHY, odd: selection under random polling
    curTag = "R3";
    resetPhase(1'b1, 1'b1, 1'b1);
    randomRun(3000);

    // R6: pause inside a cell
    curTag = "R6";
    resetPhase(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 27; i++) step(1'b1, portAddr, 1'b1, 16'h1000 + 16'(i));
    for (int i = 0; i < 5; i++)  step(1'b0, portAddr, 1'b0, '0);
    for (int i = 0; i < 3; i++)  step(1'b1, portAddr, 1'b0, '0);
    for (int i = 0; i < 30; i++) step(1'b0, portAddr, 1'b0, '0);

    // R10: cell completion and cell start on one edge
    curTag = "R10";
    resetPhase(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 53; i++) step(1'b1, portAddr, 1'b1, 16'hA000 + 16'(i));
    step(1'b0, portAddr, 1'b1, 16'hBEEF);
    for (int i = 0; i < 60; i++) step(1'b0, portAddr, 1'b0, '0);

    // R9: fill the store in byte mode, single-PHY, even parity
    curTag = "R9";
    resetPhase(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < DEPTH + 3; i++) step(1'b1, 5'h00, 1'b1, 16'h5500 + 16'(i));
    // R7: enable held low yields one cell only
    curTag = "R7";
    for (int i = 0; i < 130; i++) step(1'b0, 5'h00, 1'b0, '0);
    step(1'b1, 5'h00, 1'b0, '0);
    for (int i = 0; i < 60; i++) step(1'b0, 5'h00, 1'b0, '0);
    randomRun(3000);

    // byte mode on a shared bus, wide single-PHY
    curTag = "R3";
    resetPhase(1'b0, 1'b1, 1'b1);
    randomRun(1500);
    curTag = "R7";
    resetPhase(1'b1, 1'b0, 1'b1);
    randomRun(1500);

    step(1'b1, 5'h00, 1'b0, '0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule